// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing and Level Flags

This block is a first-in first-out buffer for 9-bit words that links a producer on one clock to a consumer on an unrelated clock. Storage depth is a power-of-two parameter. Pointers cross between the domains as Gray code through two-flop synchronisers. Every flag is therefore conservative: the buffer cannot accept a word it has no room for, and it cannot hand out a word it does not hold.

A mode pin is captured while the reset is high. In request mode, every word, the first included, is fetched by a read request. In fall-through mode, the oldest word is moved into the output register without a request, so the buffer holds one word more than its memory. The mode also flips the polarity of the two main flags. Five flags come out: data-available, room, half-full, almost-empty and almost-full. The almost-empty and almost-full offsets are static inputs.

Top module: `dualmode_fifo`

## Requirements
- R1: While `rst` is high, the `mode_sel` value is captured and kept until the next reset (0 = request mode, 1 = fall-through mode). During reset the FIFO empties, and the flags settle to `aempty_n`=0, `half_n`=1, `afull_n`=1. They also settle to `rd_flag`=0 and `wr_flag`=1 in request mode, or to `rd_flag`=1 and `wr_flag`=0 in fall-through mode.
- R2: A `wclk` edge with `wr_en_n`=0 stores `wr_data` only while room is indicated. Room is `wr_flag`=1 in request mode and `wr_flag`=0 in fall-through mode. Otherwise the write is ignored.
- R3: In request mode, `rd_flag`=1 means data is available. A `rclk` edge with `rd_en_n`=0 and `rd_flag`=1 places the oldest word on `rd_data` after that edge. With `rd_flag`=0, `rd_en_n` is ignored and `rd_data` holds.
- R4: In fall-through mode, `rd_flag`=0 means `rd_data` holds the oldest word. A word written into an empty FIFO shows there on the third `rclk` rising edge after its write edge, with no request, and not before. A `rclk` edge with `rd_en_n`=0 and `rd_flag`=0 consumes that word.
- R5: With no reads, full is indicated after DEPTH accepted writes in request mode (`wr_flag`=0). In fall-through mode it is indicated after DEPTH+1 writes (`wr_flag`=1).
- R6: `aempty_n` is 1 exactly when the settled word count k satisfies k >= n+1 in request mode, or k >= n+2 in fall-through mode, where n = `empty_off`.
- R7: `half_n` is 0 exactly when k >= DEPTH/2+1 in request mode, or k >= DEPTH/2+2 in fall-through mode.
- R8: `afull_n` is 0 exactly when k >= DEPTH-m in request mode, or k >= DEPTH+1-m in fall-through mode, where m = `full_off`.
- R9: Under unrelated clocks with writes and reads at the same time, words leave in write order with none lost or duplicated. Data is never indicated when none is held, and room is never indicated at capacity.
- R10: When the FIFO is full, the first read releases the full indication once the pointer has crossed domains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Master reset, active high, synchronous to both clocks, held for several cycles of each |
| mode_sel | input | 1 | Timing mode, captured during reset (0 request, 1 fall-through) |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | 9 | Word to store |
| rd_en_n | input | 1 | Read request, active low |
| empty_off | input | AW | Almost-empty offset n |
| full_off | input | AW | Almost-full offset m |
| rd_data | output | 9 | Output register |
| rd_flag | output | 1 | Data-available flag, polarity per mode (see R3, R4) |
| wr_flag | output | 1 | Room flag, polarity per mode (see R2, R5) |
| half_n | output | 1 | Low when at least half full |
| aempty_n | output | 1 | Low when almost empty |
| afull_n | output | 1 | Low when almost full |

## Verification
A pointer that advances wrongly, or a Gray code that decodes wrongly, first shows as a word out of order on `rd_data`. The reference queue catches this on the first read that reaches the bad location, which is at most DEPTH+1 reads later. A flag threshold that is off by one, or a capacity that ignores the output register, shows as a wrong flag level a dozen clocks after the fill level settles on the boundary value. The bench stops at every level while filling and while draining. A synchroniser stage that is missing or extra shifts the fall-through first-word latency away from three read edges. A lost data-available condition or room condition is caught on the clock where the flag disagrees with the queue.

// File: rtl/dualmode_fifo_pkg.sv
package dualmode_fifo_pkg;

    localparam int DATA_W = 9;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    typedef struct packed {
        logic room;
        logic half_n;
        logic afull_n;
    } wr_flags_t;

    typedef struct packed {
        logic avail;
        logic aempty_n;
    } rd_flags_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dualmode_fifo_sync.sv
module dualmode_fifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dualmode_fifo_mem.sv
module dualmode_fifo_mem
    import dualmode_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dualmode_fifo_wr_ctl.sv
module dualmode_fifo_wr_ctl
    import dualmode_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          mode_sel,
    input  logic          wr_en_n,
    input  logic [AW:0]   rgray_s,
    input  logic [AW-1:0] full_off,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output fifo_mode_e    wmode,
    output wr_flags_t     wflags
);
    localparam int        PW      = AW + 1;
    localparam logic [AW:0] CAP   = PW'(DEPTH);
    localparam logic [AW:0] HALF  = PW'(DEPTH / 2 + 1);

    logic [AW:0] wbin_nxt;
    logic [AW:0] rbin_s;
    logic [AW:0] used;
    logic [AW:0] af_level;

    assign we       = !wr_en_n && wflags.room;
    assign waddr    = wbin[AW-1:0];
    assign wbin_nxt = wbin + {{AW{1'b0}}, we};
    assign rbin_s   = PW'(gray_to_bin(32'(rgray_s)));
    assign used     = wbin_nxt - rbin_s;
    assign af_level = CAP - {1'b0, full_off};

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            wmode  <= fifo_mode_e'(mode_sel);
            wflags <= '{room: 1'b1, half_n: 1'b1, afull_n: 1'b1};
        end else begin
            wbin           <= wbin_nxt;
            wgray          <= PW'(bin_to_gray(32'(wbin_nxt)));
            wflags.room    <= (used != CAP);
            wflags.half_n  <= !(used >= HALF);
            wflags.afull_n <= !(used >= af_level);
        end
    end
endmodule

// File: rtl/dualmode_fifo_rd_ctl.sv
module dualmode_fifo_rd_ctl
    import dualmode_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              rclk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              rd_en_n,
    input  logic [AW:0]       wgray_s,
    input  logic [AW-1:0]     empty_off,
    input  logic [DATA_W-1:0] mem_q,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rbin,
    output logic [AW:0]       rgray,
    output fifo_mode_e        rmode,
    output rd_flags_t         rflags,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PW = AW + 1;

    logic [AW:0] wbin_s;
    logic [AW:0] rbin_nxt;
    logic [AW:0] level;
    logic        nonempty_q;
    logic        out_valid;
    logic        aempty_q;
    logic        mem_has;
    logic        pop_std;
    logic        load_ft;
    logic        pop;

    assign wbin_s   = PW'(gray_to_bin(32'(wgray_s)));
    assign raddr    = rbin[AW-1:0];
    assign mem_has  = (wbin_s != rbin);
    assign pop_std  = (rmode == MODE_STD) && !rd_en_n && nonempty_q;
    assign load_ft  = (rmode == MODE_FWFT) && mem_has && (!out_valid || !rd_en_n);
    assign pop      = pop_std || load_ft;
    assign rbin_nxt = rbin + {{AW{1'b0}}, pop};
    assign level    = wbin_s - rbin_nxt;

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin       <= '0;
            rgray      <= '0;
            rmode      <= fifo_mode_e'(mode_sel);
            nonempty_q <= 1'b0;
            out_valid  <= 1'b0;
            aempty_q   <= 1'b0;
            rd_data    <= '0;
        end else begin
            rbin       <= rbin_nxt;
            rgray      <= PW'(bin_to_gray(32'(rbin_nxt)));
            nonempty_q <= (level != '0);
            aempty_q   <= (level > {1'b0, empty_off});
            if (pop) begin
                rd_data <= mem_q;
            end
            if (load_ft) begin
                out_valid <= 1'b1;
            end else if ((rmode == MODE_FWFT) && !rd_en_n) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign rflags.avail    = (rmode == MODE_FWFT) ? out_valid : nonempty_q;
    assign rflags.aempty_n = aempty_q;
endmodule

// File: rtl/dualmode_fifo.sv
module dualmode_fifo
    import dualmode_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic [AW-1:0]     empty_off,
    input  logic [AW-1:0]     full_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              half_n,
    output logic              aempty_n,
    output logic              afull_n
);
    logic [AW:0]       wbin, rbin, wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0]     waddr, raddr;
    logic              we;
    logic [DATA_W-1:0] mem_q;
    fifo_mode_e        wmode, rmode;
    wr_flags_t         wflags;
    rd_flags_t         rflags;

    dualmode_fifo_sync #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst(rst), .d(wgray), .q(wgray_s)
    );

    dualmode_fifo_sync #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst(rst), .d(rgray), .q(rgray_s)
    );

    dualmode_fifo_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    dualmode_fifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .wclk(wclk), .rst(rst), .mode_sel(mode_sel), .wr_en_n(wr_en_n),
        .rgray_s(rgray_s), .full_off(full_off), .we(we), .waddr(waddr),
        .wbin(wbin), .wgray(wgray), .wmode(wmode), .wflags(wflags)
    );

    dualmode_fifo_rd_ctl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .rclk(rclk), .rst(rst), .mode_sel(mode_sel), .rd_en_n(rd_en_n),
        .wgray_s(wgray_s), .empty_off(empty_off), .mem_q(mem_q),
        .raddr(raddr), .rbin(rbin), .rgray(rgray), .rmode(rmode),
        .rflags(rflags), .rd_data(rd_data)
    );

    assign rd_flag  = (rmode == MODE_FWFT) ? !rflags.avail : rflags.avail;
    assign wr_flag  = (wmode == MODE_FWFT) ? !wflags.room  : wflags.room;
    assign aempty_n = rflags.aempty_n;
    assign half_n   = wflags.half_n;
    assign afull_n  = wflags.afull_n;
endmodule

// File: rtl/dualmode_fifo_chk.sv
module dualmode_fifo_chk
    import dualmode_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic        wclk,
    input logic        rclk,
    input logic        rst,
    input logic        rd_flag,
    input logic        wr_flag,
    input logic        half_n,
    input logic        aempty_n,
    input logic        afull_n,
    input fifo_mode_e  wmode,
    input fifo_mode_e  rmode,
    input logic [AW:0] wbin,
    input logic [AW:0] rbin
);
    logic [AW:0] occupancy;
    logic        full_shown;
    logic        empty_std;

    assign occupancy  = wbin - rbin;
    assign full_shown = (wr_flag == (wmode == MODE_FWFT));
    assign empty_std  = (rmode == MODE_STD) && !rd_flag;

    a_r1_reset_wr_flags: assert property (@(posedge wclk)
        rst |=> (half_n && afull_n));

    a_r1_reset_rd_flags: assert property (@(posedge rclk)
        rst |=> !aempty_n);

    a_r2_no_write_when_full: assert property (@(posedge wclk) disable iff (rst)
        full_shown |=> $stable(wbin));

    a_r3_no_read_when_empty: assert property (@(posedge rclk) disable iff (rst)
        empty_std |=> $stable(rbin));

    a_r6_empty_is_almost_empty: assert property (@(posedge rclk) disable iff (rst)
        empty_std |-> !aempty_n);

    a_r7_full_is_half_full: assert property (@(posedge wclk) disable iff (rst)
        full_shown |-> (!half_n && !afull_n));

    a_r9_no_overflow: assert property (@(posedge wclk) disable iff (rst)
        occupancy <= (AW+1)'(DEPTH));
endmodule

bind dualmode_fifo dualmode_fifo_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (.*);

// File: tb/dualmode_fifo_test.sv
module dualmode_fifo_test;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic       wr_en_n = 1'b1;
    logic [8:0] wr_data = '0;
    logic       rd_en_n = 1'b1;
    logic [AW-1:0] empty_off = 4'd3;
    logic [AW-1:0] full_off = 4'd4;
    logic [8:0] rd_data;
    logic       rd_flag, wr_flag, half_n, aempty_n, afull_n;

    int  checks = 0;
    int  fails = 0;
    bit  cur_ft = 1'b0;
    int  model[$];
    bit  pend = 1'b0;
    int  pend_val = 0;

    always #2   wclk = ~wclk;
    always #3.1 rclk = ~rclk;

    dualmode_fifo #(.DEPTH(DEPTH)) uut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .mode_sel(mode_sel),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .empty_off(empty_off), .full_off(full_off), .rd_data(rd_data),
        .rd_flag(rd_flag), .wr_flag(wr_flag), .half_n(half_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit room_seen();
        return cur_ft ? !wr_flag : wr_flag;
    endfunction

    function automatic bit avail_seen();
        return cur_ft ? !rd_flag : rd_flag;
    endfunction

    // write-side reference model (R2, R9)
    always @(posedge wclk) begin
        if (!rst) begin
            if (room_seen())
                chk(model.size() < (cur_ft ? DEPTH + 1 : DEPTH), "R9",
                    "room shown at capacity", model.size(), DEPTH);
            if (!wr_en_n && room_seen()) model.push_back(int'(wr_data));
        end
    end

    // read-side reference model (R3, R4, R9)
    always @(posedge rclk) begin
        if (!rst) begin
            if (avail_seen())
                chk(model.size() > 0, "R9", "data shown while model empty",
                    model.size(), 1);
            if (!rd_en_n && avail_seen() && model.size() > 0) begin
                pend_val = model.pop_front();
                pend = !cur_ft;
            end
        end
    end

    always @(negedge rclk) begin
        if (!rst) begin
            if (pend) begin
                chk(int'(rd_data) == pend_val, "R3", "request-mode word",
                    int'(rd_data), pend_val);
                pend = 1'b0;
            end
            if (cur_ft && !rd_flag && model.size() > 0)
                chk(int'(rd_data) == model[0], "R4", "fall-through head word",
                    int'(rd_data), model[0]);
        end
    end

    task automatic do_write(input logic [8:0] d);
        @(negedge wclk);
        wr_en_n = 1'b0;
        wr_data = d;
        @(negedge wclk);
        wr_en_n = 1'b1;
    endtask

    task automatic do_read();
        @(negedge rclk);
        rd_en_n = 1'b0;
        @(negedge rclk);
        rd_en_n = 1'b1;
    endtask

    task automatic settle_check(input int n, input int m);
        int k;
        repeat (12) @(posedge rclk);
        @(negedge wclk);
        k = model.size();
        if (!cur_ft) begin
            chk(rd_flag == (k > 0), "R3", "data flag at level", k, int'(k > 0));
            chk(wr_flag == (k < DEPTH), "R5", "room flag at level", k, int'(k < DEPTH));
            chk(half_n == !(k >= DEPTH/2 + 1), "R7", "half flag at level", k, int'(!(k >= DEPTH/2 + 1)));
            chk(afull_n == !(k >= DEPTH - m), "R8", "almost-full at level", k, int'(!(k >= DEPTH - m)));
            chk(aempty_n == (k >= n + 1), "R6", "almost-empty at level", k, int'(k >= n + 1));
        end else begin
            chk(rd_flag == !(k > 0), "R4", "ready flag at level", k, int'(!(k > 0)));
            chk(wr_flag == (k == DEPTH + 1), "R5", "full flag at level", k, int'(k == DEPTH + 1));
            chk(half_n == !(k >= DEPTH/2 + 2), "R7", "half flag at level", k, int'(!(k >= DEPTH/2 + 2)));
            chk(afull_n == !(k >= DEPTH + 1 - m), "R8", "almost-full at level", k, int'(!(k >= DEPTH + 1 - m)));
            chk(aempty_n == (k >= n + 2), "R6", "almost-empty at level", k, int'(k >= n + 2));
        end
    endtask

    task automatic run_mode(input bit ft, input int n, input int m);
        int cap;
        logic [8:0] held;
        cap = ft ? DEPTH + 1 : DEPTH;
        rst = 1'b1;
        mode_sel = ft;
        cur_ft = ft;
        empty_off = AW'(n);
        full_off = AW'(m);
        model.delete();
        pend = 1'b0;
        repeat (5) @(negedge rclk);
        @(negedge wclk);
        chk(rd_flag == ft, "R1", "reset data flag", int'(rd_flag), int'(ft));
        chk(wr_flag == !ft, "R1", "reset room flag", int'(wr_flag), int'(!ft));
        chk(!aempty_n && half_n && afull_n, "R1", "reset level flags",
            int'({aempty_n, half_n, afull_n}), 3);
        rst = 1'b0;
        mode_sel = !ft;
        settle_check(n, m);

        // first-word latency (R3 request / R4 fall-through)
        @(negedge wclk);
        wr_en_n = 1'b0;
        wr_data = 9'h1A5;
        @(posedge wclk);
        fork
            begin @(negedge wclk); wr_en_n = 1'b1; end
        join_none
        repeat (2) @(posedge rclk);
        #1;
        chk(avail_seen() == 1'b0, ft ? "R4" : "R3", "word shown before third edge",
            int'(avail_seen()), 0);
        @(posedge rclk);
        #1;
        chk(avail_seen() == 1'b1, ft ? "R4" : "R3", "word shown on third edge",
            int'(avail_seen()), 1);
        if (ft) chk(rd_data == 9'h1A5, "R4", "fall-through word without request",
                    int'(rd_data), 'h1A5);
        do_read();
        settle_check(n, m);

        // fill one word at a time, one extra write at capacity (R2, R5-R8)
        for (int i = 0; i <= cap; i++) begin
            do_write(9'($urandom));
            settle_check(n, m);
        end
        chk(model.size() == cap, "R5", "accepted words at capacity", model.size(), cap);
        chk(room_seen() == 1'b0, "R2", "write at capacity left full", int'(room_seen()), 0);

        // drain one word at a time (R10, R6-R8)
        do_read();
        settle_check(n, m);
        chk(room_seen() == 1'b1, "R10", "first read releases full", int'(room_seen()), 1);
        while (model.size() > 0) begin
            do_read();
            settle_check(n, m);
        end

        // requests while empty are ignored (R3, R4)
        held = rd_data;
        repeat (3) do_read();
        settle_check(n, m);
        if (!ft) chk(rd_data == held, "R3", "data held on empty request",
                     int'(rd_data), int'(held));
        chk(avail_seen() == 1'b0, ft ? "R4" : "R3", "still empty after requests",
            int'(avail_seen()), 0);

        // concurrent traffic on unrelated clocks (R9)
        fork
            begin
                repeat (700) begin
                    @(negedge wclk);
                    wr_en_n = ($urandom % 3) == 0;
                    wr_data = 9'($urandom);
                end
                @(negedge wclk);
                wr_en_n = 1'b1;
            end
            begin
                repeat (500) begin
                    @(negedge rclk);
                    rd_en_n = ($urandom % 2) == 0;
                end
                @(negedge rclk);
                rd_en_n = 1'b1;
            end
        join
        settle_check(n, m);
        while (model.size() > 0) begin
            do_read();
            settle_check(n, m);
        end
        chk(avail_seen() == 1'b0, "R9", "empty after full drain", int'(avail_seen()), 0);
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        run_mode(1'b0, 3, 4);
        run_mode(1'b1, 2, 5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule